// File: doc/BRIEF.md
# SPI Word FIFO Controller

This block sits between a register interface and a serial shift engine. It buffers outgoing words in a transmit queue and incoming words in a receive queue. Each queue holds up to eight 32-bit words. For each queue it reports the fill level, the empty and full flags, and a threshold status. It also raises a sticky overrun flag when a received word finds no room, and a timeout flag when received data sits unread for too long.

Software pushes words into the transmit queue and pops words from the receive queue. The shift engine takes words from the head of the transmit queue. It signals when it has finished a word and delivers received words into the receive queue. When queue mode is on, a word written by software marks the controller busy. The busy state lasts until the transmit queue has drained and the engine reports its final word finished.

Top module: `spi_fifo_ctrl`

## Requirements
- R1: Each queue keeps up to 8 words in first-in first-out order. The count output is 4 bits wide and holds the number of stored words. Empty is 1 exactly when the count is 0, and full is 1 exactly when the count is 8. After reset both queues are empty and all flags and `rx_data` are 0.
- R2: `rx_thr_hit` is 1 when the receive count is strictly greater than the 2-bit `rx_thr`, and 0 otherwise.
- R3: `tx_thr_hit` is 1 when the transmit count is less than or equal to the 2-bit `tx_thr`, and 0 otherwise.
- R4: An `eng_rx_valid` word that arrives while the receive queue is full, with no accepted pop in the same cycle, is discarded and sets `rx_overrun`. A 1 on `ovr_w1c` clears the flag. If a new overrun happens in the same cycle as `ovr_w1c`, the set wins.
- R5: While the receive queue is non-empty and no pop is accepted, each `sclk_tick` pulse advances an idle counter. On the 64th pulse `rx_timeout` is set. An accepted pop clears both the flag and the counter. A 1 on `tmo_w1c` also clears the flag, but a set in the same cycle wins. An empty queue or a receive clear resets the counter.
- R6: A one-cycle `tx_clr` or `rx_clr` pulse empties its queue at the next edge. In that cycle the clear overrides any push or pop on the same queue: the push is dropped, no word is popped, and no overrun is raised.
- R7: With `fifo_mode` at 1, an accepted transmit push sets `busy`. `busy` returns to 0 at the edge where `eng_word_done` is 1, the transmit queue is empty and no push is accepted. A set in the same cycle wins over the clear.
- R8: `rx_data` is a registered output. It takes the head word at the edge that accepts a pop. A pop of an empty receive queue leaves `rx_data` and the count unchanged.
- R9: A transmit push while the transmit queue is full, with no engine load in the same cycle, is ignored. The count stays 8 and the stored words are unchanged.
- R10: A push and an accepted pop in the same cycle leave the queue's count unchanged, and this holds even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | Enables automatic busy on transmit push |
| tx_push | input | 1 | Software write into the transmit queue |
| tx_wdata | input | 32 | Word to push |
| tx_clr | input | 1 | One-cycle transmit queue clear |
| tx_thr | input | 2 | Transmit threshold |
| rx_pop | input | 1 | Software read of the receive queue |
| rx_clr | input | 1 | One-cycle receive queue clear |
| rx_thr | input | 2 | Receive threshold |
| ovr_w1c | input | 1 | Clears the overrun flag |
| tmo_w1c | input | 1 | Clears the timeout flag |
| sclk_tick | input | 1 | One pulse per serial clock period |
| eng_load | input | 1 | Engine takes the transmit head word |
| eng_word_done | input | 1 | Engine finished a word |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| tx_head | output | 32 | Word at the transmit queue head |
| tx_count | output | 4 | Transmit fill level |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_thr_hit | output | 1 | Transmit threshold status |
| rx_data | output | 32 | Last word popped from the receive queue |
| rx_count | output | 4 | Receive fill level |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_thr_hit | output | 1 | Receive threshold status |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_timeout | output | 1 | Receive idle timeout flag |
| busy | output | 1 | Transfer in progress |

## Verification
Some properties are checked on every cycle by assertions. The count never exceeds the depth. A clear always leaves the queue empty. A full queue does not grow. A balanced push and pop keeps the count steady. A blocked received word always raises overrun. An accepted push in queue mode always raises busy. An empty-queue pop leaves `rx_data` unchanged, and an accepted pop always drops the timeout flag.

Other behaviour only shows up when the bench's behavioural model is compared with the outputs on every clock. This covers word ordering, threshold boundaries across all four settings, the exact 64th-tick timeout cycle, the precedence of set over write-1-clear, and busy holding across several engine words.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    localparam int DEF_DATA_W    = 32;
    localparam int DEF_DEPTH     = 8;
    localparam int DEF_THR_W     = 2;
    localparam int DEF_TMO_TICKS = 64;

    typedef struct packed {
        logic busy;
        logic ovr;
    } ctl_flags_t;
endpackage

// File: rtl/spi_word_queue.sv
module spi_word_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          wr_ok
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } q_st_t;

    q_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic rd_ok;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign count = st_q.cnt;
    assign head  = mem[st_q.rp];
    assign rd_ok = rd && !empty && !clr;
    assign wr_ok = wr && !clr && (!full || rd_ok);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (rd_ok) st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
            if (wr_ok) st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            if (wr_ok && !rd_ok)      st_d.cnt = st_q.cnt + 1'b1;
            else if (rd_ok && !wr_ok) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[st_q.wp] <= wdata;
    end

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
    p_full_no_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd && !clr) |=> (count == CW'(DEPTH)));
    p_push_pop_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rd && !empty && !clr) |=> $stable(count));
endmodule

// File: rtl/spi_rx_idle_timer.sv
module spi_rx_idle_timer #(
    parameter int LIMIT = 64,
    parameter int TW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic armed,
    input  logic restart,
    input  logic w1c,
    output logic flag
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          flag;
    } t_st_t;

    t_st_t st_d, st_q;
    logic fire;

    assign fire = armed && !restart && tick && (st_q.cnt == TW'(LIMIT - 1));
    assign flag = st_q.flag;

    always_comb begin
        st_d = st_q;
        if (!armed || restart) st_d.cnt = '0;
        else if (tick)         st_d.cnt = fire ? '0 : st_q.cnt + 1'b1;
        if (fire)                 st_d.flag = 1'b1;
        else if (restart || w1c)  st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_pop_drops_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !flag);
    p_idle_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !$rose(flag));
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl #(
    parameter int DATA_W    = spi_fifo_pkg::DEF_DATA_W,
    parameter int DEPTH     = spi_fifo_pkg::DEF_DEPTH,
    parameter int THR_W     = spi_fifo_pkg::DEF_THR_W,
    parameter int TMO_TICKS = spi_fifo_pkg::DEF_TMO_TICKS,
    parameter int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_clr,
    input  logic [THR_W-1:0]  tx_thr,
    input  logic              rx_pop,
    input  logic              rx_clr,
    input  logic [THR_W-1:0]  rx_thr,
    input  logic              ovr_w1c,
    input  logic              tmo_w1c,
    input  logic              sclk_tick,
    input  logic              eng_load,
    input  logic              eng_word_done,
    input  logic              eng_rx_valid,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic [DATA_W-1:0] tx_head,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              tx_thr_hit,
    output logic [DATA_W-1:0] rx_data,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_thr_hit,
    output logic              rx_overrun,
    output logic              rx_timeout,
    output logic              busy
);
    import spi_fifo_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        ctl_flags_t        f;
    } top_st_t;

    top_st_t st_d, st_q;
    logic tx_wr_ok, rx_wr_ok, rx_pop_ok, rx_drop;
    logic [DATA_W-1:0] rx_head;

    spi_word_queue #(.W(DATA_W), .DEPTH(DEPTH), .CW(CNT_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .wr(tx_push), .wdata(tx_wdata),
        .rd(eng_load), .head(tx_head), .count(tx_count), .empty(tx_empty),
        .full(tx_full), .wr_ok(tx_wr_ok));

    spi_word_queue #(.W(DATA_W), .DEPTH(DEPTH), .CW(CNT_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .wr(eng_rx_valid), .wdata(eng_rx_data),
        .rd(rx_pop), .head(rx_head), .count(rx_count), .empty(rx_empty),
        .full(rx_full), .wr_ok(rx_wr_ok));

    assign rx_pop_ok = rx_pop && !rx_empty && !rx_clr;
    assign rx_drop   = eng_rx_valid && !rx_clr && !rx_wr_ok;

    spi_rx_idle_timer #(.LIMIT(TMO_TICKS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .tick(sclk_tick), .armed(!rx_empty && !rx_clr),
        .restart(rx_pop_ok), .w1c(tmo_w1c), .flag(rx_timeout));

    assign rx_thr_hit = (rx_count >  CNT_W'(rx_thr));
    assign tx_thr_hit = (tx_count <= CNT_W'(tx_thr));
    assign rx_data    = st_q.rdata;
    assign rx_overrun = st_q.f.ovr;
    assign busy       = st_q.f.busy;

    always_comb begin
        st_d = st_q;
        if (rx_pop_ok) st_d.rdata = rx_head;
        if (rx_drop)      st_d.f.ovr = 1'b1;
        else if (ovr_w1c) st_d.f.ovr = 1'b0;
        if (fifo_mode && tx_wr_ok)           st_d.f.busy = 1'b1;
        else if (eng_word_done && tx_empty)  st_d.f.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_full_drop_sets_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && eng_rx_valid && !rx_pop && !rx_clr) |=> rx_overrun);
    p_push_sets_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && tx_push && !tx_full && !tx_clr) |=> busy);
    p_empty_pop_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |=> $stable(rx_data));
    p_rx_pop_shrinks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_empty && !rx_clr && !eng_rx_valid) |=> (rx_count == $past(rx_count) - 1'b1));
endmodule

// File: tb/spi_fifo_ctrl_tb.sv
module spi_fifo_ctrl_tb;
    localparam int CLK_P = 10;

    logic clk = 0, rst_n = 0;
    logic fifo_mode = 0, tx_push = 0, tx_clr = 0, rx_pop = 0, rx_clr = 0;
    logic ovr_w1c = 0, tmo_w1c = 0, sclk_tick = 0, eng_load = 0, eng_word_done = 0, eng_rx_valid = 0;
    logic [31:0] tx_wdata = 0, eng_rx_data = 0;
    logic [1:0] tx_thr = 0, rx_thr = 0;
    logic [31:0] tx_head, rx_data;
    logic [3:0] tx_count, rx_count;
    logic tx_empty, tx_full, tx_thr_hit, rx_empty, rx_full, rx_thr_hit, rx_overrun, rx_timeout, busy;

    int nvec = 0, nerr = 0;
    bit done = 0;
    logic [31:0] mtx[$], mrx[$];
    logic [31:0] mrd = 0;
    bit mov = 0, mtmo = 0, mbusy = 0;
    int mcnt = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_fifo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_clr(tx_clr), .tx_thr(tx_thr), .rx_pop(rx_pop), .rx_clr(rx_clr), .rx_thr(rx_thr),
        .ovr_w1c(ovr_w1c), .tmo_w1c(tmo_w1c), .sclk_tick(sclk_tick), .eng_load(eng_load),
        .eng_word_done(eng_word_done), .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
        .tx_head(tx_head), .tx_count(tx_count), .tx_empty(tx_empty), .tx_full(tx_full),
        .tx_thr_hit(tx_thr_hit), .rx_data(rx_data), .rx_count(rx_count), .rx_empty(rx_empty),
        .rx_full(rx_full), .rx_thr_hit(rx_thr_hit), .rx_overrun(rx_overrun),
        .rx_timeout(rx_timeout), .busy(busy));

    task automatic check(string tag, string nm, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int ts = mtx.size(), rs = mrx.size();
        bit t_rd, t_wr, r_rd, r_wr, r_ovf, armed, fire;
        if (!rst_n) begin
            mtx.delete(); mrx.delete(); mrd = 0; mov = 0; mtmo = 0; mbusy = 0; mcnt = 0;
            return;
        end
        t_rd  = eng_load && ts > 0 && !tx_clr;
        t_wr  = tx_push && !tx_clr && (ts < 8 || t_rd);
        r_rd  = rx_pop && rs > 0 && !rx_clr;
        r_wr  = eng_rx_valid && !rx_clr && (rs < 8 || r_rd);
        r_ovf = eng_rx_valid && !rx_clr && !r_wr;
        armed = rs > 0 && !rx_clr;
        fire  = armed && !r_rd && sclk_tick && mcnt == 63;
        if (!armed || r_rd) mcnt = 0;
        else if (sclk_tick) mcnt = fire ? 0 : mcnt + 1;
        if (fire) mtmo = 1; else if (r_rd || tmo_w1c) mtmo = 0;
        if (r_ovf) mov = 1; else if (ovr_w1c) mov = 0;
        if (fifo_mode && t_wr) mbusy = 1; else if (eng_word_done && ts == 0) mbusy = 0;
        if (tx_clr) mtx.delete();
        else begin
            if (t_rd) void'(mtx.pop_front());
            if (t_wr) mtx.push_back(tx_wdata);
        end
        if (rx_clr) mrx.delete();
        else begin
            if (r_rd) mrd = mrx.pop_front();
            if (r_wr) mrx.push_back(eng_rx_data);
        end
    endtask

    task automatic compare();
        int ts = mtx.size(), rs = mrx.size();
        check("R1 R6 R9 R10", "tx_count", 32'(tx_count), 32'(ts));
        check("R1 R6", "tx_empty", 32'(tx_empty), 32'(ts == 0));
        check("R1 R9", "tx_full", 32'(tx_full), 32'(ts == 8));
        check("R3", "tx_thr_hit", 32'(tx_thr_hit), 32'(ts <= int'(tx_thr)));
        if (ts > 0) check("R1", "tx_head", tx_head, mtx[0]);
        check("R1 R6 R10", "rx_count", 32'(rx_count), 32'(rs));
        check("R1 R6", "rx_empty", 32'(rx_empty), 32'(rs == 0));
        check("R1", "rx_full", 32'(rx_full), 32'(rs == 8));
        check("R2", "rx_thr_hit", 32'(rx_thr_hit), 32'(rs > int'(rx_thr)));
        check("R1 R8", "rx_data", rx_data, mrd);
        check("R4", "rx_overrun", 32'(rx_overrun), 32'(mov));
        check("R5", "rx_timeout", 32'(rx_timeout), 32'(mtmo));
        check("R7", "busy", 32'(busy), 32'(mbusy));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        tx_push = 0; tx_clr = 0; rx_pop = 0; rx_clr = 0; ovr_w1c = 0; tmo_w1c = 0;
        sclk_tick = 0; eng_load = 0; eng_word_done = 0; eng_rx_valid = 0;
    endtask

    task automatic txw(logic [31:0] d);
        tx_push = 1; tx_wdata = d; cyc();
    endtask

    task automatic rxw(logic [31:0] d);
        eng_rx_valid = 1; eng_rx_data = d; cyc();
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        @(negedge clk); cyc(); cyc();
        rst_n = 1;
        cyc();                                   // R1 reset state
        // R7: queue mode busy across several engine words
        fifo_mode = 1;
        txw(32'hA1); txw(32'hA2); txw(32'hA3);
        for (int i = 0; i < 3; i++) begin
            eng_load = 1; cyc();
            cyc(); eng_word_done = 1; cyc();     // busy held until drained
        end
        eng_word_done = 1; cyc();
        // R9 R3: fill transmit queue past full, sweeping thresholds
        for (int i = 0; i < 10; i++) begin tx_thr = 2'(i); txw(32'h100 + i); end
        // R10: push and load together while full
        tx_push = 1; tx_wdata = 32'hBEEF; eng_load = 1; cyc();
        // R6: clear beats a push in the same cycle
        tx_clr = 1; tx_push = 1; tx_wdata = 32'h55; cyc();
        cyc();
        // R4 R2: overfill receive queue with thresholds sweeping
        for (int i = 0; i < 10; i++) begin rx_thr = 2'(i + 1); rxw(32'h200 + i); end
        ovr_w1c = 1; eng_rx_valid = 1; eng_rx_data = 32'h777; cyc();   // R4 set wins
        ovr_w1c = 1; cyc();                                            // R4 cleared
        // R10: full, pop and push together, no overrun
        rx_pop = 1; eng_rx_valid = 1; eng_rx_data = 32'h300; cyc();
        // R8: drain and pop past empty
        for (int i = 0; i < 10; i++) begin rx_pop = 1; cyc(); end
        // R5: timeout after 64 ticks, cleared by pop
        rxw(32'h400);
        for (int i = 0; i < 70; i++) begin sclk_tick = 1; cyc(); end
        rx_pop = 1; cyc();
        // R5: write-1-clear, then partial window interrupted by pop
        rxw(32'h401); rxw(32'h402);
        for (int i = 0; i < 64; i++) begin sclk_tick = 1; cyc(); end
        tmo_w1c = 1; cyc();
        for (int i = 0; i < 40; i++) begin sclk_tick = 1; cyc(); end
        rx_pop = 1; cyc();
        for (int i = 0; i < 40; i++) begin sclk_tick = (i % 2 == 0); cyc(); end
        // R6: receive clear with pop and push in the same cycle
        rx_clr = 1; rx_pop = 1; eng_rx_valid = 1; cyc();
        cyc();
        // mixed traffic across all requirements
        for (int i = 0; i < 2000; i++) begin
            fifo_mode = $urandom_range(0, 3) != 0;
            tx_push = $urandom_range(0, 1); tx_wdata = $urandom;
            eng_load = $urandom_range(0, 2) == 0; eng_word_done = $urandom_range(0, 3) == 0;
            eng_rx_valid = $urandom_range(0, 1); eng_rx_data = $urandom;
            rx_pop = $urandom_range(0, 2) == 0; sclk_tick = $urandom_range(0, 1);
            tx_clr = $urandom_range(0, 60) == 0; rx_clr = $urandom_range(0, 60) == 0;
            ovr_w1c = $urandom_range(0, 9) == 0; tmo_w1c = $urandom_range(0, 19) == 0;
            tx_thr = 2'($urandom); rx_thr = 2'($urandom);
            cyc();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule